// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block forms the operand address for the displacement-based register-indirect addressing modes of a processor. It takes the instruction's 3-bit mode field and 3-bit register field, the current value of the selected base address register, the program counter, and one extension word. From these it computes a 32-bit address. Address-register-based and PC-relative forms are covered, and each comes with a 16-bit displacement variant and an indexed variant.

In the indexed variants the extension word is read as a brief format. Its low byte is a signed 8-bit displacement. Its upper bits pick an index register and say how wide that register is. The block selects the index register through a combinational read port, `idx_sel_o`, and the register file answers on `idx_data_i` in the same cycle. The PC input must already hold the address of the extension word. Any mode and register combination the block does not handle raises an error flag.

A control state machine has two states, IDLE and HOLD:
- **Launch:** on `start_i`, the result is registered and the machine moves from IDLE to HOLD.
- **Relaunch:** another `start_i` while in HOLD stays in HOLD and loads a new result.
- **Retire:** with no `start_i`, the machine moves from HOLD back to IDLE.
- `valid_o` is high only in HOLD. The address and error outputs hold their values until the next start.

Top module: `ea_calc`

## Requirements
- R1: Mode 3'b101 gives address = base + the 16-bit extension word sign-extended to 32 bits, with the error flag low.
- R2: Mode 3'b110 gives address = base + the extended index register + the sign-extended byte displacement held in extension bits 7:0.
- R3: Mode 3'b111 with register field 3'b010 gives address = PC + the sign-extended 16-bit extension word.
- R4: Mode 3'b111 with register field 3'b011 gives address = PC + the extended index register + the sign-extended displacement in extension bits 7:0.
- R5: `idx_sel_o` is 4 bits wide. Bit 3 equals extension bit 15 (0 = data register, 1 = address register). Bits 2:0 equal extension bits 14:12 (the register number).
- R6: Extension bit 11 picks the index width. When it is 0, the low 16 bits of the index register are sign-extended. When it is 1, all 32 bits are used.
- R7: All additions wrap modulo 2^32.
- R8: Modes 3'b000 to 3'b100 raise the error flag, and so does mode 3'b111 with a register field other than 3'b010 or 3'b011. In that case the address output is zero.
- R9: `valid_o` is high in exactly the cycle after each cycle that has `start_i` high, and low otherwise. Address and error keep their values while `start_i` is low.
- R10: After reset, `valid_o`, `err_o` and `addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; the inputs are sampled in this cycle |
| mode_i | input | 3 | Addressing mode field |
| reg_i | input | 3 | Register field |
| base_i | input | 32 | Value of the base address register |
| pc_i | input | 32 | Address of the extension word |
| ext_i | input | 16 | Extension word |
| idx_sel_o | output | 4 | Index register select: {type, number} |
| idx_data_i | input | 32 | Index register value returned for idx_sel_o |
| valid_o | output | 1 | Result valid pulse |
| addr_o | output | 32 | Computed effective address |
| err_o | output | 1 | Unsupported mode/register combination |

## Verification
The 16-bit displacement forms are run with both positive and negative displacements. This shows that true sign extension is applied rather than zero extension. The indexed forms walk through all sixteen index registers, each preloaded with a distinct value, so a wrong type or number decode gives a wrong sum. The same forms are also run with index values whose bit 15 and bit 31 differ, which tells word-size and long-size index handling apart. A base near the top of the address space checks the wrap, every illegal combination is checked for the error flag, and back-to-back starts against idle gaps check the valid pulse and the held outputs.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int EA_ADDR_W = 32;

    typedef enum logic [2:0] {
        EK_DISP_AN,
        EK_IDX_AN,
        EK_DISP_PC,
        EK_IDX_PC,
        EK_BAD
    } ea_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_HOLD
    } ea_state_e;

    typedef struct packed {
        logic       idx_is_addr;
        logic [2:0] idx_num;
        logic       idx_long;
        logic [7:0] disp8;
    } ea_brief_t;
endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] ext_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ext_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
        end else begin : g_same
            assign ext_o = val_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic [2:0] reg_i,
    output ea_kind_e   kind_o
);
    always_comb begin
        kind_o = EK_BAD;
        unique case (mode_i)
            3'b101:  kind_o = EK_DISP_AN;
            3'b110:  kind_o = EK_IDX_AN;
            3'b111: begin
                unique case (reg_i)
                    3'b010:  kind_o = EK_DISP_PC;
                    3'b011:  kind_o = EK_IDX_PC;
                    default: kind_o = EK_BAD;
                endcase
            end
            default: kind_o = EK_BAD;
        endcase
    end
endmodule

// File: rtl/ea_brief_decode.sv
module ea_brief_decode
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [15:11]     hi_i,
    input  logic [7:0]       lo_i,
    input  logic [ADDR_W-1:0] idx_data_i,
    output logic [3:0]       idx_sel_o,
    output logic [ADDR_W-1:0] idx_term_o,
    output logic [ADDR_W-1:0] disp_term_o
);
    ea_brief_t          brief;
    logic [ADDR_W-1:0]  idx_word_ext;

    always_comb begin
        brief.idx_is_addr = hi_i[15];
        brief.idx_num     = hi_i[14:12];
        brief.idx_long    = hi_i[11];
        brief.disp8       = lo_i;
    end

    assign idx_sel_o = {brief.idx_is_addr, brief.idx_num};

    ea_sext #(.IN_W(8), .OUT_W(ADDR_W)) u_disp_ext (
        .val_i (brief.disp8),
        .ext_o (disp_term_o)
    );

    ea_sext #(.IN_W(16), .OUT_W(ADDR_W)) u_idx_ext (
        .val_i (idx_data_i[15:0]),
        .ext_o (idx_word_ext)
    );

    assign idx_term_o = brief.idx_long ? idx_data_i : idx_word_ext;
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = EA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [2:0]        reg_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [15:0]       ext_i,
    output logic [3:0]        idx_sel_o,
    input  logic [ADDR_W-1:0] idx_data_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              err_o
);
    ea_kind_e           kind;
    ea_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  disp16_term;
    logic [ADDR_W-1:0]  brief_idx;
    logic [ADDR_W-1:0]  brief_disp;
    logic [ADDR_W-1:0]  base_sel;
    logic [ADDR_W-1:0]  idx_sel_term;
    logic [ADDR_W-1:0]  disp_sel_term;
    logic [ADDR_W-1:0]  sum;
    logic               bad;
    logic [ADDR_W-1:0]  addr_q;
    logic               err_q;

    ea_mode_decode u_mode (
        .mode_i (mode_i),
        .reg_i  (reg_i),
        .kind_o (kind)
    );

    ea_brief_decode #(.ADDR_W(ADDR_W)) u_brief (
        .hi_i        (ext_i[15:11]),
        .lo_i        (ext_i[7:0]),
        .idx_data_i  (idx_data_i),
        .idx_sel_o   (idx_sel_o),
        .idx_term_o  (brief_idx),
        .disp_term_o (brief_disp)
    );

    ea_sext #(.IN_W(16), .OUT_W(ADDR_W)) u_disp16 (
        .val_i (ext_i),
        .ext_o (disp16_term)
    );

    // operand selection by addressing kind
    always_comb begin
        base_sel      = '0;
        idx_sel_term  = '0;
        disp_sel_term = '0;
        bad           = 1'b0;
        unique case (kind)
            EK_DISP_AN: begin
                base_sel      = base_i;
                disp_sel_term = disp16_term;
            end
            EK_IDX_AN: begin
                base_sel      = base_i;
                idx_sel_term  = brief_idx;
                disp_sel_term = brief_disp;
            end
            EK_DISP_PC: begin
                base_sel      = pc_i;
                disp_sel_term = disp16_term;
            end
            EK_IDX_PC: begin
                base_sel      = pc_i;
                idx_sel_term  = brief_idx;
                disp_sel_term = brief_disp;
            end
            default: bad = 1'b1;
        endcase
    end

    assign sum = base_sel + idx_sel_term + disp_sel_term;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_HOLD;
            ST_HOLD: state_d = start_i ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else if (start_i) begin
            addr_q <= bad ? '0 : sum;
            err_q  <= bad;
        end
    end

    assign valid_o = (state_q == ST_HOLD);
    assign addr_o  = addr_q;
    assign err_o   = err_q;
endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        mode_i,
    input logic [2:0]        reg_i,
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [15:0]       ext_i,
    input logic              valid_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              err_o
);
    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o); // R9
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o); // R9
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(addr_o) && $stable(err_o))); // R9
    AST_DISP_AN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 3'b101) |=>
        (!err_o && addr_o == $past(base_i + {{(ADDR_W-16){ext_i[15]}}, ext_i}))); // R1
    AST_DISP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i == 3'b111 && reg_i == 3'b010) |=>
        (!err_o && addr_o == $past(pc_i + {{(ADDR_W-16){ext_i[15]}}, ext_i}))); // R3
    AST_LOW_MODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i < 3'b101) |=> (err_o && addr_o == '0)); // R8
endmodule

bind ea_calc ea_calc_chk #(.ADDR_W(ADDR_W)) u_ea_calc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .reg_i   (reg_i),
    .base_i  (base_i),
    .pc_i    (pc_i),
    .ext_i   (ext_i),
    .valid_o (valid_o),
    .addr_o  (addr_o),
    .err_o   (err_o)
);

// File: tb/test_ea_calc.sv
module test_ea_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [2:0]  reg_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] pc_i = '0;
    logic [15:0] ext_i = '0;
    logic [3:0]  idx_sel_o;
    logic [31:0] idx_data_i;
    logic        valid_o;
    logic [31:0] addr_o;
    logic        err_o;

    logic [31:0] dreg [8];
    logic [31:0] areg [8];

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign idx_data_i = idx_sel_o[3] ? areg[idx_sel_o[2:0]] : dreg[idx_sel_o[2:0]];

    ea_calc i_ea_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .reg_i(reg_i),
        .base_i(base_i), .pc_i(pc_i), .ext_i(ext_i), .idx_sel_o(idx_sel_o),
        .idx_data_i(idx_data_i), .valid_o(valid_o), .addr_o(addr_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_idx(input logic [15:0] ext);
        logic [31:0] r;
        r = ext[15] ? areg[ext[14:12]] : dreg[ext[14:12]];
        if (!ext[11]) r = 32'($signed(r[15:0]));
        return r;
    endfunction

    function automatic logic [32:0] model(input logic [2:0] m, input logic [2:0] rg,
                                          input logic [31:0] b, input logic [31:0] p,
                                          input logic [15:0] ext);
        logic [31:0] d16, d8;
        d16 = 32'($signed(ext));
        d8  = 32'($signed(ext[7:0]));
        if (m == 3'b101) return {1'b0, b + d16};
        if (m == 3'b110) return {1'b0, b + model_idx(ext) + d8};
        if (m == 3'b111 && rg == 3'b010) return {1'b0, p + d16};
        if (m == 3'b111 && rg == 3'b011) return {1'b0, p + model_idx(ext) + d8};
        return {1'b1, 32'h0};
    endfunction

    task automatic launch(input string tag, input logic [2:0] m, input logic [2:0] rg,
                          input logic [31:0] b, input logic [31:0] p, input logic [15:0] ext);
        logic [32:0] e;
        e = model(m, rg, b, p, ext);
        @(negedge clk);
        mode_i = m; reg_i = rg; base_i = b; pc_i = p; ext_i = ext; start_i = 1'b1;
        #1;
        if (m == 3'b110 || (m == 3'b111 && rg == 3'b011))
            check({tag, " R5 idx_sel"}, 32'(idx_sel_o), 32'({ext[15], ext[14:12]}));
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " R9 valid"}, 32'(valid_o), 32'd1);
        check({tag, " addr"}, addr_o, e[31:0]);
        check({tag, " err"}, 32'(err_o), 32'(e[32]));
    endtask

    task automatic t_reset;
        check("R10 valid", 32'(valid_o), 0);
        check("R10 err", 32'(err_o), 0);
        check("R10 addr", addr_o, 0);
    endtask

    task automatic t_disp_an;
        launch("R1 pos", 3'b101, 3'b000, 32'h0000_1000, 32'h0, 16'h0234);
        launch("R1 neg", 3'b101, 3'b011, 32'h0000_1000, 32'h0, 16'hFFF0);
    endtask

    task automatic t_disp_pc;
        launch("R3 pos", 3'b111, 3'b010, 32'hDEAD_0000, 32'h0004_0000, 16'h7FFE);
        launch("R3 neg", 3'b111, 3'b010, 32'h0, 32'h0004_0000, 16'h8000);
    endtask

    task automatic t_idx_all;
        for (int t = 0; t < 2; t++)
            for (int n = 0; n < 8; n++) begin
                launch("R2 sel", 3'b110, 3'b001, 32'h0010_0000, 32'h0,
                       {t[0], n[2:0], 1'b1, 3'b000, 8'h10});
                launch("R4 sel", 3'b111, 3'b011, 32'h0, 32'h2000_0000,
                       {t[0], n[2:0], 1'b1, 3'b000, 8'hF0});
            end
    endtask

    task automatic t_idx_size;
        dreg[5] = 32'h0001_8000;
        areg[2] = 32'h8000_7FFF;
        launch("R6 word neg", 3'b110, 3'b0, 32'h0100_0000, 32'h0, 16'h5000);
        launch("R6 long", 3'b110, 3'b0, 32'h0100_0000, 32'h0, 16'h5800);
        launch("R6 word pos", 3'b111, 3'b011, 32'h0, 32'h0000_0100, 16'hA080);
        launch("R6 long pc", 3'b111, 3'b011, 32'h0, 32'h0000_0100, 16'hA880);
    endtask

    task automatic t_wrap;
        launch("R7 wrap disp", 3'b101, 3'b0, 32'hFFFF_FFF0, 32'h0, 16'h0020);
        dreg[1] = 32'hFFFF_FFFF;
        launch("R7 wrap idx", 3'b110, 3'b0, 32'hFFFF_FFFF, 32'h0, 16'h187F);
        launch("R7 wrap low", 3'b111, 3'b010, 32'h0, 32'h0000_0004, 16'hFFF0);
    endtask

    task automatic t_illegal;
        for (int m = 0; m < 5; m++) launch("R8 mode", m[2:0], 3'b011, 32'h1234, 32'h5678, 16'h0010);
        launch("R8 r0", 3'b111, 3'b000, 32'h1234, 32'h5678, 16'h0010);
        launch("R8 r1", 3'b111, 3'b001, 32'h1234, 32'h5678, 16'h0010);
        for (int r = 4; r < 8; r++) launch("R8 rhi", 3'b111, r[2:0], 32'h1234, 32'h5678, 16'h0010);
    endtask

    task automatic t_timing;
        logic [32:0] e;
        e = model(3'b101, 3'b0, 32'h0000_4000, 32'h0, 16'h0040);
        launch("R9 first", 3'b101, 3'b0, 32'h0000_4000, 32'h0, 16'h0040);
        @(negedge clk);
        base_i = 32'hFFFF_0000; mode_i = 3'b000;
        check("R9 valid drops", 32'(valid_o), 0);
        check("R9 addr held", addr_o, e[31:0]);
        @(negedge clk);
        check("R9 still held", addr_o, e[31:0]);
        check("R9 err held", 32'(err_o), 0);
        @(negedge clk);
        start_i = 1'b1; mode_i = 3'b101; base_i = 32'h10; ext_i = 16'h1;
        @(negedge clk);
        base_i = 32'h20;
        check("R9 b2b v1", 32'(valid_o), 1);
        check("R9 b2b a1", addr_o, 32'h11);
        @(negedge clk);
        start_i = 1'b0;
        check("R9 b2b v2", 32'(valid_o), 1);
        check("R9 b2b a2", addr_o, 32'h21);
        @(negedge clk);
        check("R9 b2b end", 32'(valid_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            dreg[i] = 32'h0000_0100 * (i + 1) + 32'h1;
            areg[i] = 32'h0100_0000 * (i + 1) + 32'h20;
        end
        #12;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disp_an();
        t_disp_pc();
        t_idx_all();
        t_idx_size();
        t_wrap();
        t_illegal();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule